// File: doc/BRIEF.md
# PCI Configuration Status Error Tracker

This block holds the error flags of a PCI function's configuration status word and the few command-word enables they depend on. It watches the shared address/data lines, the command/byte-enable lines and the parity line. It checks even parity only in the bus phases where the function is responsible for it. Any failure goes into sticky flags, which software clears by writing ones through a configuration write port. The same enables gate the raw I/O, memory and expansion-ROM address decodes before the function claims a cycle.

The surrounding bus engine supplies phase qualifiers: the address phase, whether this function owns the transaction as initiator, whether it was selected as target, and the IRDY/TRDY handshake. It also reports a PERR indication sampled during its own memory writes and a master-abort termination pulse. The parity line covers the previous clock's address/data and command lines, so the block keeps those lines for one cycle before it compares them. On an address parity error, a one-cycle system-error pulse goes out when reporting is enabled.

Top module: `pci_err_status`

## Requirements
- R1: While the active-low hard reset is asserted, all three status flags, the I/O, memory, parity-response and system-error enables, and the ROM enable read back as 0.
- R2: Configuration dword 1 reads {detected parity error at bit 31, signaled system error at bit 30, received master abort at bit 29, zeros, system-error enable at bit 8, parity-response enable at bit 6, memory enable at bit 1, I/O enable at bit 0}. Dword 12 carries the ROM enable at bit 0. Command bits are written through byte lanes 0 and 1, and the ROM enable through lane 0.
- R3: A write to dword 1 with byte lane 3 enabled clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: When a flag's set event and its write-one-to-clear happen in the same cycle, the flag stays set.
- R5: The soft reset leaves all status flags and enables unchanged.
- R6: As target, every address phase is checked for even parity over AD, C/BE and the PAR value sampled one clock later. A failure sets the detected-parity flag whatever the parity-response enable is.
- R7: An address parity error sets the signaled-system-error flag and produces a one-cycle sysErrPulse in the cycle after PAR is sampled, but only when the system-error and parity-response enables are both 1.
- R8: As selected target, data parity is checked only on write commands (I/O write 0011, memory write 0111, memory write-and-invalidate 1111, configuration write 1011) and only when IRDY and TRDY are both high. Read data and wait-state data are never checked.
- R9: As initiator, data parity is checked on memory reads (0110, 1100, 1110) when IRDY and TRDY are high. During memory writes (0111, 1111), a PERR indication from the target sets the detected-parity flag.
- R10: A master-abort termination of a transaction this function owns sets the received-master-abort flag on the next edge.
- R11: An I/O claim requires the I/O enable. A memory claim requires the memory enable. A ROM claim requires both the ROM enable and the memory enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous soft reset; flushes in-flight checks only |
| ad | input | AD_W | Address/data lines |
| cbe | input | 4 | Command / byte-enable lines |
| par | input | 1 | Parity line covering the previous cycle |
| addrPhase | input | 1 | Current cycle is an address phase |
| mstActive | input | 1 | This function owns the current transaction |
| tgtSel | input | 1 | This function is the selected target |
| irdy | input | 1 | Initiator ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| perrIn | input | 1 | Target-reported data parity error (active high) |
| mstAbort | input | 1 | Master-abort termination pulse |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | CFG_AW | Configuration write dword index |
| cfgWrBe | input | 4 | Configuration write byte lanes |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdAddr | input | CFG_AW | Configuration read dword index |
| cfgRdData | output | 32 | Combinational configuration read data |
| ioDecode | input | 1 | Raw I/O address match |
| memDecode | input | 1 | Raw memory address match |
| romDecode | input | 1 | Raw expansion-ROM address match |
| ioClaim | output | 1 | Gated I/O claim |
| memClaim | output | 1 | Gated memory claim |
| romClaim | output | 1 | Gated expansion-ROM claim |
| sysErrPulse | output | 1 | One-cycle system-error signal |

## Verification
The assertions assume the bus engine is well behaved. Master-abort pulses arrive only while this function owns the transaction. Every data phase comes after the address phase that latched its command. Configuration writes never coincide with the soft reset when the enables are being compared. The stimulus drives each transaction as a separate sequence on falling edges, with all qualifiers idle between sequences. It raises mstAbort only together with mstActive, and issues the soft reset alone. Parity errors are injected by inverting the correct even-parity value one clock after the phase it covers.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

  localparam int CBE_W  = 4;
  localparam int DATA_W = 32;

  // dword indices and bit positions that software decodes
  localparam int CMD_DW   = 1;
  localparam int ROM_DW   = 12;
  localparam int IOEN_B   = 0;
  localparam int MEMEN_B  = 1;
  localparam int PERREN_B = 6;
  localparam int SERREN_B = 8;
  localparam int ROMEN_B  = 0;
  localparam int FLAG_LO  = 29;  // flags occupy [31:29]
  localparam int NFLAG    = 3;   // index 2 parity, 1 system error, 0 master abort

  localparam logic [3:0] CMD_IDLE   = 4'b0000;
  localparam logic [3:0] CMD_IOWR   = 4'b0011;
  localparam logic [3:0] CMD_MEMRD  = 4'b0110;
  localparam logic [3:0] CMD_MEMWR  = 4'b0111;
  localparam logic [3:0] CMD_CFGWR  = 4'b1011;
  localparam logic [3:0] CMD_MEMRDM = 4'b1100;
  localparam logic [3:0] CMD_MEMRDL = 4'b1110;
  localparam logic [3:0] CMD_MEMWRI = 4'b1111;

  typedef struct packed {
    logic chkLoad;     // capture AD/CBE for a parity check next cycle
    logic chkIsAddr;   // the captured phase is an address phase
    logic mstPerrSet;  // target reported a write data parity error
    logic mstAbortSet; // owned transaction ended in master abort
  } strobe_t;

  function automatic logic isSlvWrite(input logic [3:0] c);
    return (c == CMD_IOWR) || (c == CMD_MEMWR) || (c == CMD_MEMWRI) || (c == CMD_CFGWR);
  endfunction

  function automatic logic isMemRead(input logic [3:0] c);
    return (c == CMD_MEMRD) || (c == CMD_MEMRDM) || (c == CMD_MEMRDL);
  endfunction

  function automatic logic isMemWrite(input logic [3:0] c);
    return (c == CMD_MEMWR) || (c == CMD_MEMWRI);
  endfunction

endpackage

// File: rtl/pci_err_ctl.sv
module pci_err_ctl
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             hardRstN,
  input  logic             softRst,
  input  logic             addrPhase,
  input  logic [CBE_W-1:0] cbe,
  input  logic             mstActive,
  input  logic             tgtSel,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             perrIn,
  input  logic             mstAbort,
  output strobe_t          strb
);

  logic [CBE_W-1:0] cmdQ;
  logic xfer, slvAddrChk, slvDataChk, mstDataChk;

  // command of the transaction in progress
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)      cmdQ <= CMD_IDLE;
    else if (softRst)   cmdQ <= CMD_IDLE;
    else if (addrPhase) cmdQ <= cbe;
  end

  always_comb begin
    xfer       = irdy & trdy & ~addrPhase;
    slvAddrChk = addrPhase & ~mstActive;
    slvDataChk = xfer & ~mstActive & tgtSel & isSlvWrite(cmdQ);
    mstDataChk = xfer & mstActive & isMemRead(cmdQ);

    strb.chkLoad     = slvAddrChk | slvDataChk | mstDataChk;
    strb.chkIsAddr   = slvAddrChk;
    strb.mstPerrSet  = mstActive & ~addrPhase & perrIn & isMemWrite(cmdQ);
    strb.mstAbortSet = mstActive & mstAbort;
  end

endmodule

// File: rtl/pci_err_dp.sv
module pci_err_dp
  import pci_err_pkg::*;
#(
  parameter int AD_W   = 32,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  strobe_t           strb,
  input  logic [AD_W-1:0]   ad,
  input  logic [CBE_W-1:0]  cbe,
  input  logic              par,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [3:0]        cfgWrBe,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [CFG_AW-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              ioDecode,
  input  logic              memDecode,
  input  logic              romDecode,
  output logic              ioClaim,
  output logic              memClaim,
  output logic              romClaim,
  output logic              sysErrPulse,
  output logic [NFLAG-1:0]  statFlags,
  output logic [NFLAG-1:0]  setEv,
  output logic [4:0]        enOut
);

  // parity pipeline: PAR arrives one clock after the phase it covers
  logic            pendQ, pendAddrQ;
  logic [AD_W-1:0] adQ;
  logic [CBE_W-1:0] cbeQ;
  logic            parBad;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      pendQ     <= 1'b0;
      pendAddrQ <= 1'b0;
      adQ       <= '0;
      cbeQ      <= '0;
    end else begin
      pendQ     <= strb.chkLoad & ~softRst;
      pendAddrQ <= strb.chkIsAddr & ~softRst;
      if (strb.chkLoad) begin
        adQ  <= ad;
        cbeQ <= cbe;
      end
    end
  end

  assign parBad = pendQ & (^{adQ, cbeQ, par});

  // command-word enables and ROM enable
  logic ioEn, memEn, perrEn, serrEn, romEn;
  logic wrCmd, wrRom, wrStat;

  always_comb begin
    wrCmd  = cfgWrEn && (cfgWrAddr == CFG_AW'(CMD_DW));
    wrRom  = cfgWrEn && (cfgWrAddr == CFG_AW'(ROM_DW));
    wrStat = wrCmd && cfgWrBe[3];
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      ioEn   <= 1'b0;
      memEn  <= 1'b0;
      perrEn <= 1'b0;
      serrEn <= 1'b0;
      romEn  <= 1'b0;
    end else begin
      if (wrCmd && cfgWrBe[0]) begin
        ioEn   <= cfgWrData[IOEN_B];
        memEn  <= cfgWrData[MEMEN_B];
        perrEn <= cfgWrData[PERREN_B];
      end
      if (wrCmd && cfgWrBe[1]) serrEn <= cfgWrData[SERREN_B];
      if (wrRom && cfgWrBe[0]) romEn  <= cfgWrData[ROMEN_B];
    end
  end

  // sticky status flags, set wins over clear
  logic [NFLAG-1:0] clrVec;
  logic             serrSet;

  always_comb begin
    serrSet  = parBad & pendAddrQ & serrEn & perrEn;
    setEv[2] = parBad | strb.mstPerrSet;
    setEv[1] = serrSet;
    setEv[0] = strb.mstAbortSet;
    clrVec   = wrStat ? cfgWrData[FLAG_LO +: NFLAG] : '0;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN) q <= 1'b0;
      else           q <= setEv[i] | (q & ~clrVec[i]);
    end
    assign statFlags[i] = q;
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) sysErrPulse <= 1'b0;
    else           sysErrPulse <= serrSet;
  end

  // read port
  always_comb begin
    cfgRdData = '0;
    if (cfgRdAddr == CFG_AW'(CMD_DW)) begin
      cfgRdData[FLAG_LO +: NFLAG] = statFlags;
      cfgRdData[SERREN_B]         = serrEn;
      cfgRdData[PERREN_B]         = perrEn;
      cfgRdData[MEMEN_B]          = memEn;
      cfgRdData[IOEN_B]           = ioEn;
    end else if (cfgRdAddr == CFG_AW'(ROM_DW)) begin
      cfgRdData[ROMEN_B] = romEn;
    end
  end

  // decode gating
  assign ioClaim  = ioDecode & ioEn;
  assign memClaim = memDecode & memEn;
  assign romClaim = romDecode & romEn & memEn;

  assign enOut = {romEn, serrEn, perrEn, memEn, ioEn};

  logic unusedWr;
  assign unusedWr = ^{cfgWrData[28:9], cfgWrData[7], cfgWrData[5:2], cfgWrBe[2]};

endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
  import pci_err_pkg::*;
#(
  parameter int AD_W   = 32,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic [AD_W-1:0]   ad,
  input  logic [3:0]        cbe,
  input  logic              par,
  input  logic              addrPhase,
  input  logic              mstActive,
  input  logic              tgtSel,
  input  logic              irdy,
  input  logic              trdy,
  input  logic              perrIn,
  input  logic              mstAbort,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [3:0]        cfgWrBe,
  input  logic [31:0]       cfgWrData,
  input  logic [CFG_AW-1:0] cfgRdAddr,
  output logic [31:0]       cfgRdData,
  input  logic              ioDecode,
  input  logic              memDecode,
  input  logic              romDecode,
  output logic              ioClaim,
  output logic              memClaim,
  output logic              romClaim,
  output logic              sysErrPulse
);

  strobe_t          strb;
  logic [NFLAG-1:0] statFlags;
  logic [NFLAG-1:0] setEv;
  logic [4:0]       enOut;

  pci_err_ctl u_ctl (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .softRst   (softRst),
    .addrPhase (addrPhase),
    .cbe       (cbe),
    .mstActive (mstActive),
    .tgtSel    (tgtSel),
    .irdy      (irdy),
    .trdy      (trdy),
    .perrIn    (perrIn),
    .mstAbort  (mstAbort),
    .strb      (strb)
  );

  pci_err_dp #(.AD_W(AD_W), .CFG_AW(CFG_AW)) u_dp (
    .clk         (clk),
    .hardRstN    (hardRstN),
    .softRst     (softRst),
    .strb        (strb),
    .ad          (ad),
    .cbe         (cbe),
    .par         (par),
    .cfgWrEn     (cfgWrEn),
    .cfgWrAddr   (cfgWrAddr),
    .cfgWrBe     (cfgWrBe),
    .cfgWrData   (cfgWrData),
    .cfgRdAddr   (cfgRdAddr),
    .cfgRdData   (cfgRdData),
    .ioDecode    (ioDecode),
    .memDecode   (memDecode),
    .romDecode   (romDecode),
    .ioClaim     (ioClaim),
    .memClaim    (memClaim),
    .romClaim    (romClaim),
    .sysErrPulse (sysErrPulse),
    .statFlags   (statFlags),
    .setEv       (setEv),
    .enOut       (enOut)
  );

endmodule

// File: rtl/pci_err_chk.sv
module pci_err_chk #(
  parameter int CFG_AW = 6
) (
  input logic              clk,
  input logic              hardRstN,
  input logic              softRst,
  input logic              cfgWrEn,
  input logic [CFG_AW-1:0] cfgWrAddr,
  input logic              wrLane3,
  input logic [2:0]        wrFlagBits,
  input logic [2:0]        statFlags,
  input logic [2:0]        setEv,
  input logic [4:0]        enOut,
  input logic              mstActive,
  input logic              mstAbort,
  input logic              sysErrPulse,
  input logic              ioClaim,
  input logic              romClaim
);

  logic statWr;
  assign statWr = cfgWrEn && (cfgWrAddr == CFG_AW'(1)) && wrLane3;

  p_sticky_r3: assert property (@(posedge clk) disable iff (!hardRstN)
    (statFlags[2] && !(statWr && wrFlagBits[2])) |=> statFlags[2]);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!hardRstN)
    (statWr && wrFlagBits[0] && !setEv[0]) |=> !statFlags[0]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!hardRstN)
    setEv[0] |=> statFlags[0]);

  p_soft_keep_r5: assert property (@(posedge clk) disable iff (!hardRstN)
    (softRst && !cfgWrEn) |=> $stable(enOut));

  p_serr_gate_r7: assert property (@(posedge clk) disable iff (!hardRstN)
    $rose(statFlags[1]) |-> $past(enOut[3] && enOut[2]));

  p_pulse_flags_r7: assert property (@(posedge clk) disable iff (!hardRstN)
    sysErrPulse |-> (statFlags[2] && statFlags[1]));

  p_mabort_r10: assert property (@(posedge clk) disable iff (!hardRstN)
    (mstActive && mstAbort) |=> statFlags[0]);

  p_io_gate_r11: assert property (@(posedge clk) disable iff (!hardRstN)
    ioClaim |-> enOut[0]);

  p_rom_gate_r11: assert property (@(posedge clk) disable iff (!hardRstN)
    romClaim |-> (enOut[4] && enOut[1]));

endmodule

bind pci_err_status pci_err_chk #(.CFG_AW(CFG_AW)) u_chk (
  .clk         (clk),
  .hardRstN    (hardRstN),
  .softRst     (softRst),
  .cfgWrEn     (cfgWrEn),
  .cfgWrAddr   (cfgWrAddr),
  .wrLane3     (cfgWrBe[3]),
  .wrFlagBits  (cfgWrData[31:29]),
  .statFlags   (statFlags),
  .setEv       (setEv),
  .enOut       (enOut),
  .mstActive   (mstActive),
  .mstAbort    (mstAbort),
  .sysErrPulse (sysErrPulse),
  .ioClaim     (ioClaim),
  .romClaim    (romClaim)
);

// File: tb/tb_pci_err_status.sv
`timescale 1ns/1ps
module tb_pci_err_status;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        par = 1'b0;
  logic        addrPhase = 1'b0, mstActive = 1'b0, tgtSel = 1'b0;
  logic        irdy = 1'b0, trdy = 1'b0, perrIn = 1'b0, mstAbort = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgWrAddr = '0;
  logic [3:0]  cfgWrBe = '0;
  logic [31:0] cfgWrData = '0;
  logic [5:0]  cfgRdAddr = '0;
  logic [31:0] cfgRdData;
  logic        ioDecode = 1'b0, memDecode = 1'b0, romDecode = 1'b0;
  logic        ioClaim, memClaim, romClaim, sysErrPulse;

  always #10 clk = ~clk;  // 50 MHz

  pci_err_status dut (.*);

  typedef struct {
    int          kind;   // 0 cfg read, 1 claims {io,mem,rom}, 2 sysErrPulse
    logic [5:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int pushCnt = 0, doneCnt = 0;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // driver side: queue an expectation and wait for the monitor to consume it
  task automatic expect_item(input int kind, input logic [5:0] addr,
                             input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    q.push_back(it);
    pushCnt++;
    wait (doneCnt == pushCnt);
  endtask

  // monitor: pop and compare against what the design presents
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      wait (pushCnt != doneCnt);
      it = q.pop_front();
      if (it.kind == 0) cfgRdAddr = it.addr;
      #1;
      case (it.kind)
        0:       got = cfgRdData;
        1:       got = {29'b0, ioClaim, memClaim, romClaim};
        default: got = {31'b0, sysErrPulse};
      endcase
      nChecks++;
      if (got !== it.exp) begin
        nFail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
      doneCnt++;
    end
  end

  function automatic logic evenPar(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic cfgWrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d; cfgWrBe = be;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrBe = '0;
  endtask

  // target-side transaction: address phase, one data phase, then check slot
  task automatic slvTxn(input logic [3:0] cmd, input logic addrBad,
                        input logic doData, input logic hs, input logic dataBad);
    logic [31:0] a = 32'h1234_5670;
    logic [31:0] d = 32'hA5A5_0F0F;
    @(negedge clk);
    addrPhase = 1'b1; ad = a; cbe = cmd; tgtSel = 1'b1;
    @(negedge clk);
    addrPhase = 1'b0; par = evenPar(a, cmd) ^ addrBad;
    ad = d; cbe = 4'b0000;
    irdy = doData & hs; trdy = doData & hs;
    @(negedge clk);
    par = evenPar(d, 4'b0000) ^ dataBad;
    irdy = 1'b0; trdy = 1'b0; ad = '0;
    @(negedge clk);
    par = 1'b0; tgtSel = 1'b0;
  endtask

  // address-only target cycle; samples sysErrPulse in the cycle it is due
  task automatic slvAddr(input logic [3:0] cmd, input logic bad,
                         input logic expPulse, input string tag);
    logic [31:0] a = 32'h0F0F_1230;
    @(negedge clk);
    addrPhase = 1'b1; ad = a; cbe = cmd;
    @(negedge clk);
    addrPhase = 1'b0; par = evenPar(a, cmd) ^ bad; ad = '0; cbe = '0;
    @(negedge clk);
    par = 1'b0;
    expect_item(2, 6'd0, {31'b0, expPulse}, tag);
    @(negedge clk);
    expect_item(2, 6'd0, 32'h0, {tag, " pulse width"});
  endtask

  task automatic mstTxn(input logic [3:0] cmd, input logic dataBad, input logic perr);
    logic [31:0] a = 32'h8000_1000;
    logic [31:0] d = 32'h3C3C_7E01;
    @(negedge clk);
    mstActive = 1'b1; addrPhase = 1'b1; ad = a; cbe = cmd;
    @(negedge clk);
    addrPhase = 1'b0; par = evenPar(a, cmd); ad = d; cbe = 4'b0000;
    irdy = 1'b1; trdy = 1'b1;
    @(negedge clk);
    par = evenPar(d, 4'b0000) ^ dataBad; irdy = 1'b0; trdy = 1'b0; perrIn = perr;
    @(negedge clk);
    perrIn = 1'b0; par = 1'b0; mstActive = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_item(0, 6'd1, 32'h0, "R1 dword1 in reset");
    expect_item(0, 6'd12, 32'h0, "R1 rom enable in reset");
    hardRstN = 1'b1;
    @(negedge clk);

    // enables and decode gating
    cfgWrite(6'd1, 32'h0000_0003, 4'b0011);
    expect_item(0, 6'd1, 32'h0000_0003, "R2 command readback");
    ioDecode = 1'b1; memDecode = 1'b1; romDecode = 1'b1;
    @(negedge clk);
    expect_item(1, 6'd0, 32'h6, "R11 rom needs rom enable");
    cfgWrite(6'd12, 32'h0000_0001, 4'b0001);
    expect_item(0, 6'd12, 32'h1, "R2 rom enable readback");
    expect_item(1, 6'd0, 32'h7, "R11 all claims");
    cfgWrite(6'd1, 32'h0000_0000, 4'b0011);
    expect_item(1, 6'd0, 32'h0, "R11 enables off");
    cfgWrite(6'd1, 32'h0000_0001, 4'b0011);
    expect_item(1, 6'd0, 32'h4, "R11 io only, rom blocked by memory enable");
    cfgWrite(6'd1, 32'h0000_0003, 4'b0011);

    // address parity with response disabled
    slvAddr(4'b0110, 1'b1, 1'b0, "R7 no pulse with enables off");
    expect_item(0, 6'd1, 32'h8000_0003, "R6 address parity flag, response off");
    cfgWrite(6'd1, 32'h0000_0003, 4'b1111);
    expect_item(0, 6'd1, 32'h8000_0003, "R3 zero write keeps flag");
    cfgWrite(6'd1, 32'h8000_0003, 4'b1111);
    expect_item(0, 6'd1, 32'h0000_0003, "R3 one write clears flag");

    // both enables: system error
    cfgWrite(6'd1, 32'h0000_0143, 4'b0011);
    slvAddr(4'b0010, 1'b1, 1'b1, "R7 pulse with both enables");
    expect_item(0, 6'd1, 32'hC000_0143, "R7 system error flag");
    cfgWrite(6'd1, 32'hE000_0143, 4'b1111);
    expect_item(0, 6'd1, 32'h0000_0143, "R3 clear both");

    // only system-error enable
    cfgWrite(6'd1, 32'h0000_0103, 4'b0011);
    slvAddr(4'b0111, 1'b1, 1'b0, "R7 no pulse without response enable");
    expect_item(0, 6'd1, 32'h8000_0103, "R7 no system error flag");
    cfgWrite(6'd1, 32'h8000_0143, 4'b1111);
    slvAddr(4'b0111, 1'b0, 1'b0, "R6 good address parity no pulse");
    expect_item(0, 6'd1, 32'h0000_0143, "R6 good address parity");

    // target data phases
    slvTxn(4'b0111, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_item(0, 6'd1, 32'h8000_0143, "R8 memory write data error");
    cfgWrite(6'd1, 32'h8000_0000, 4'b1000);
    slvTxn(4'b0111, 1'b0, 1'b1, 1'b0, 1'b1);
    expect_item(0, 6'd1, 32'h0000_0143, "R8 wait state not checked");
    slvTxn(4'b0110, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_item(0, 6'd1, 32'h0000_0143, "R8 read data not checked");
    slvTxn(4'b1011, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_item(0, 6'd1, 32'h8000_0143, "R8 config write data error");
    cfgWrite(6'd1, 32'h8000_0000, 4'b1000);

    // initiator data phases
    mstTxn(4'b0110, 1'b1, 1'b0);
    expect_item(0, 6'd1, 32'h8000_0143, "R9 memory read data error");
    cfgWrite(6'd1, 32'h8000_0000, 4'b1000);
    mstTxn(4'b0111, 1'b0, 1'b0);
    expect_item(0, 6'd1, 32'h0000_0143, "R9 clean memory write");
    mstTxn(4'b0111, 1'b0, 1'b1);
    expect_item(0, 6'd1, 32'h8000_0143, "R9 target reported error");
    cfgWrite(6'd1, 32'h8000_0000, 4'b1000);

    // master abort
    @(negedge clk);
    mstActive = 1'b1; mstAbort = 1'b1;
    @(negedge clk);
    mstActive = 1'b0; mstAbort = 1'b0;
    expect_item(0, 6'd1, 32'h2000_0143, "R10 master abort flag");

    // set and clear in the same cycle
    @(negedge clk);
    mstActive = 1'b1; mstAbort = 1'b1;
    cfgWrEn = 1'b1; cfgWrAddr = 6'd1; cfgWrBe = 4'b1000; cfgWrData = 32'h2000_0000;
    @(negedge clk);
    mstActive = 1'b0; mstAbort = 1'b0; cfgWrEn = 1'b0; cfgWrBe = '0;
    expect_item(0, 6'd1, 32'h2000_0143, "R4 set beats clear");

    // soft reset
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    expect_item(0, 6'd1, 32'h2000_0143, "R5 soft reset keeps flags and enables");
    expect_item(0, 6'd12, 32'h1, "R5 soft reset keeps rom enable");
    expect_item(1, 6'd0, 32'h7, "R5 claims after soft reset");

    // hard reset
    hardRstN = 1'b0;
    @(negedge clk);
    expect_item(0, 6'd1, 32'h0, "R1 hard reset clears dword1");
    expect_item(0, 6'd12, 32'h0, "R1 hard reset clears rom enable");
    hardRstN = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule